// File: doc/BRIEF.md
# UART Modem-Control and Diagnostic Loopback Unit

This unit is the modem-control slice of a 16550-class serial port. It keeps a small control register with DTR, RTS, two general-purpose outputs and a loopback switch. It drives the four active-low modem output pins from that register. It also captures the four active-low modem input pins into a status register, which records their levels and latches any change until software reads it.

When the loopback switch is on, the unit sends the transmitter's serial bit straight back into the receiver and parks the TX pin at mark. It drives every modem output pin to its inactive level and stops looking at the external modem inputs. In their place, the status register sees the unit's own control bits.

Automatic hardware flow control is disabled for as long as loopback is on. A small state machine watches for the moment loopback is switched off while the external receive line is still low. It then raises a hold-off flag, so the receiver does not report that low level as a false break.

Top module: `uart_modem_loop`

## Requirements
- R1: The control register holds DTR in bit 0, RTS in bit 1, OUT1 in bit 2, OUT2 in bit 3 and loopback in bit 4. Bits 7:5 always read 0, and the whole register resets to 0.
- R2: With loopback off, dtr_n_o, rts_n_o, op1_n_o and op2_n_o are the inverses of control bits 0, 1, 2 and 3. In the same mode tx_o follows tx_bit_i and rx_bit_o follows rx_i.
- R3: With loopback on, tx_o is 1 and all four modem output pins are 1, whatever the control bits and tx_bit_i are.
- R4: With loopback on, rx_bit_o equals tx_bit_i, and rx_i has no effect on it.
- R5: With loopback on, the status bits take their values from the control register: RTS drives CTS, DTR drives DSR, OUT1 drives RI and OUT2 drives CD. The external modem input pins have no effect on the status register or on msi_o.
- R6: Status bits 7:4 are CD, RI, DSR and CTS in true (non-inverted) sense. With loopback off they are the inverses of cd_n_i, ri_n_i, dsr_n_i and cts_n_i. With the input pins high after reset, the status register reads 0.
- R7: A change on an external modem input pin reaches the status register after exactly SYNC_STAGES+1 clock edges, and not earlier.
- R8: Bits 0, 1 and 3 (delta-CTS, delta-DSR, delta-CD) are set whenever their source changes. Bit 2 is set only when the true RI level falls from 1 to 0. This includes changes caused by a control-register write in loopback. A status read clears these bits, except that a change detected in the same cycle as the read stays set.
- R9: msi_o is high whenever any of status bits 3:0 is set, and it goes low after a read that clears them.
- R10: afc_active_o equals afc_en_i with loopback off, and is 0 with loopback on.
- R11: The state machine has three states. ST_DIRECT (loopback off) moves to ST_LOOPED on ENTER (loopback bit set). ST_LOOPED moves to ST_DIRECT on EXIT_CLEAN (bit cleared while the synchronised RX is high), or to ST_RX_GUARD on EXIT_HOLD (bit cleared while RX is low). ST_RX_GUARD moves to ST_DIRECT on RELEASE (synchronised RX high), or back to ST_LOOPED on REENTER (bit set again, which takes priority). break_hold_o is 1 exactly in ST_RX_GUARD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mcr_wr_en | input | 1 | Control register write strobe |
| mcr_wdata | input | 8 | Control register write data |
| mcr_rdata | output | 8 | Control register read value |
| msr_rd_en | input | 1 | Status register read strobe; clears the change bits |
| msr_rdata | output | 8 | Status register read value |
| msi_o | output | 1 | Modem-status interrupt request |
| tx_bit_i | input | 1 | Serial bit from the transmit shifter |
| tx_o | output | 1 | TX pin |
| rx_i | input | 1 | RX pin |
| rx_bit_o | output | 1 | Serial bit to the receive shifter |
| break_hold_o | output | 1 | Tells the receiver to suppress break detection |
| afc_en_i | input | 1 | Automatic flow control enable from configuration |
| afc_active_o | output | 1 | Effective automatic flow control enable |
| rts_n_o | output | 1 | RTS pin, active low |
| dtr_n_o | output | 1 | DTR pin, active low |
| op1_n_o | output | 1 | General-purpose output 1 pin, active low |
| op2_n_o | output | 1 | General-purpose output 2 pin, active low |
| cts_n_i | input | 1 | CTS pin, active low |
| dsr_n_i | input | 1 | DSR pin, active low |
| ri_n_i | input | 1 | RI pin, active low |
| cd_n_i | input | 1 | CD pin, active low |

## Verification
The bench builds the unit with SYNC_STAGES set to 3 instead of the default 2. This longer synchroniser makes the input latency and the guard-release delay fall on cycles that a hard-wired two-flop design would miss. Every latency check is therefore computed from that parameter. The early and on-time samples of an external-pin change, and the cycle in which the receive-line hold-off drops, show whether the chain length really follows the parameter.

// File: rtl/uart_mdm_pkg.sv
package uart_mdm_pkg;

    // Loopback supervisor states
    typedef enum logic [1:0] {
        ST_DIRECT   = 2'd0,
        ST_LOOPED   = 2'd1,
        ST_RX_GUARD = 2'd2
    } lb_state_e;

    // Control register bit positions (software-visible layout)
    localparam int MCR_DTR  = 0;
    localparam int MCR_RTS  = 1;
    localparam int MCR_OP1  = 2;
    localparam int MCR_OP2  = 3;
    localparam int MCR_LOOP = 4;
    localparam int MCR_USED = 5;

    // Index of each line inside a 4-bit modem vector (matches status nibble)
    localparam int MLN_CTS = 0;
    localparam int MLN_DSR = 1;
    localparam int MLN_RI  = 2;
    localparam int MLN_CD  = 3;
    localparam int MLN_NUM = 4;

    typedef logic [MLN_NUM-1:0] modem_vec_t;

endpackage

// File: rtl/uart_mdm_sync.sv
module uart_mdm_sync #(
    parameter int              WIDTH     = 5,
    parameter int              STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= RESET_VAL;
                else        chain_q[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= RESET_VAL;
                else        chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/uart_mdm_status.sv
module uart_mdm_status
    import uart_mdm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  modem_vec_t src_i,
    input  logic       rd_i,
    output modem_vec_t level_o,
    output modem_vec_t delta_o
);

    modem_vec_t level_q;
    modem_vec_t delta_q;
    modem_vec_t hit;

    // RI latches only on its trailing edge; the other lines on any change
    for (genvar b = 0; b < MLN_NUM; b++) begin : g_det
        if (b == MLN_RI) begin : g_trail
            assign hit[b] = level_q[b] & ~src_i[b];
        end else begin : g_any
            assign hit[b] = level_q[b] ^ src_i[b];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= '0;
            delta_q <= '0;
        end else begin
            level_q <= src_i;
            delta_q <= (rd_i ? '0 : delta_q) | hit;
        end
    end

    assign level_o = level_q;
    assign delta_o = delta_q;

endmodule

// File: rtl/uart_mdm_loop_fsm.sv
module uart_mdm_loop_fsm
    import uart_mdm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic loop_i,
    input  logic rx_sync_i,
    output logic break_hold_o
);

    lb_state_e state_q;
    lb_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_DIRECT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DIRECT: begin
                if (loop_i) state_d = ST_LOOPED;              // ENTER
            end
            ST_LOOPED: begin
                if (!loop_i) begin
                    if (rx_sync_i) state_d = ST_DIRECT;       // EXIT_CLEAN
                    else           state_d = ST_RX_GUARD;     // EXIT_HOLD
                end
            end
            ST_RX_GUARD: begin
                if (loop_i)         state_d = ST_LOOPED;      // REENTER
                else if (rx_sync_i) state_d = ST_DIRECT;      // RELEASE
            end
            default: state_d = ST_DIRECT;
        endcase
    end

    always_comb begin
        break_hold_o = (state_q == ST_RX_GUARD);
    end

endmodule

// File: rtl/uart_modem_loop.sv
module uart_modem_loop
    import uart_mdm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mcr_wr_en,
    input  logic [7:0] mcr_wdata,
    output logic [7:0] mcr_rdata,
    input  logic       msr_rd_en,
    output logic [7:0] msr_rdata,
    output logic       msi_o,
    input  logic       tx_bit_i,
    output logic       tx_o,
    input  logic       rx_i,
    output logic       rx_bit_o,
    output logic       break_hold_o,
    input  logic       afc_en_i,
    output logic       afc_active_o,
    output logic       rts_n_o,
    output logic       dtr_n_o,
    output logic       op1_n_o,
    output logic       op2_n_o,
    input  logic       cts_n_i,
    input  logic       dsr_n_i,
    input  logic       ri_n_i,
    input  logic       cd_n_i
);

    localparam int SYNC_W = MLN_NUM + 1;
    localparam int PAD_W  = 8 - MCR_USED;

    logic [MCR_USED-1:0] mcr_q;
    logic                unused_wr_hi;
    logic                loop_on;
    logic [SYNC_W-1:0]   raw_in;
    logic [SYNC_W-1:0]   synced;
    logic                rx_sync;
    modem_vec_t          ext_true;
    modem_vec_t          loop_src;
    modem_vec_t          sel_src;
    modem_vec_t          lvl;
    modem_vec_t          dlt;

    // Control register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         mcr_q <= '0;
        else if (mcr_wr_en) mcr_q <= mcr_wdata[MCR_USED-1:0];
    end
    assign unused_wr_hi = ^mcr_wdata[7:MCR_USED];
    assign mcr_rdata    = {{PAD_W{1'b0}}, mcr_q};
    assign loop_on      = mcr_q[MCR_LOOP];

    // Input synchroniser: RX plus the four modem lines, idle high
    assign raw_in = {rx_i, cd_n_i, ri_n_i, dsr_n_i, cts_n_i};

    uart_mdm_sync #(
        .WIDTH    (SYNC_W),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL({SYNC_W{1'b1}})
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (raw_in),
        .q_o  (synced)
    );

    assign rx_sync  = synced[SYNC_W-1];
    assign ext_true = ~synced[MLN_NUM-1:0];

    // Loopback cross-wiring of control bits onto status lines
    always_comb begin
        loop_src          = '0;
        loop_src[MLN_CTS] = mcr_q[MCR_RTS];
        loop_src[MLN_DSR] = mcr_q[MCR_DTR];
        loop_src[MLN_RI]  = mcr_q[MCR_OP1];
        loop_src[MLN_CD]  = mcr_q[MCR_OP2];
    end
    assign sel_src = loop_on ? loop_src : ext_true;

    uart_mdm_status u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (sel_src),
        .rd_i   (msr_rd_en),
        .level_o(lvl),
        .delta_o(dlt)
    );

    assign msr_rdata = {lvl, dlt};
    assign msi_o     = |dlt;

    // Pin and serial-path routing
    always_comb begin
        if (loop_on) begin
            tx_o     = 1'b1;
            rx_bit_o = tx_bit_i;
            rts_n_o  = 1'b1;
            dtr_n_o  = 1'b1;
            op1_n_o  = 1'b1;
            op2_n_o  = 1'b1;
        end else begin
            tx_o     = tx_bit_i;
            rx_bit_o = rx_i;
            rts_n_o  = ~mcr_q[MCR_RTS];
            dtr_n_o  = ~mcr_q[MCR_DTR];
            op1_n_o  = ~mcr_q[MCR_OP1];
            op2_n_o  = ~mcr_q[MCR_OP2];
        end
    end

    assign afc_active_o = afc_en_i & ~loop_on;

    uart_mdm_loop_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .loop_i      (loop_on),
        .rx_sync_i   (rx_sync),
        .break_hold_o(break_hold_o)
    );

endmodule

// File: rtl/uart_modem_loop_chk.sv
module uart_modem_loop_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] mcr_rdata,
    input logic       msr_rd_en,
    input logic [7:0] msr_rdata,
    input logic       msi_o,
    input logic       tx_bit_i,
    input logic       tx_o,
    input logic       rx_bit_o,
    input logic       break_hold_o,
    input logic       afc_active_o,
    input logic       rts_n_o,
    input logic       dtr_n_o,
    input logic       op1_n_o,
    input logic       op2_n_o
);

    a_r1_mcr_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        mcr_rdata[7:5] == 3'b000);

    a_r3_loop_pins_idle: assert property (@(posedge clk) disable iff (!rst_n)
        mcr_rdata[4] |-> (tx_o && rts_n_o && dtr_n_o && op1_n_o && op2_n_o));

    a_r4_loop_serial: assert property (@(posedge clk) disable iff (!rst_n)
        mcr_rdata[4] |-> (rx_bit_o == tx_bit_i));

    a_r8_delta_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ((msr_rdata[3:0] != 4'h0) && !msr_rd_en)
        |=> ((msr_rdata[3:0] & $past(msr_rdata[3:0])) == $past(msr_rdata[3:0])));

    a_r9_msi_matches_delta: assert property (@(posedge clk) disable iff (!rst_n)
        msi_o == (msr_rdata[3:0] != 4'h0));

    a_r10_afc_off_in_loop: assert property (@(posedge clk) disable iff (!rst_n)
        mcr_rdata[4] |-> !afc_active_o);

    a_r11_guard_after_exit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(break_hold_o) |-> $past(!mcr_rdata[4]));

endmodule

bind uart_modem_loop uart_modem_loop_chk i_chk (.*);

// File: tb/test_uart_modem_loop.sv
`timescale 1ns/1ps
module test_uart_modem_loop;

    localparam int SYNC = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mcr_wr_en = 1'b0;
    logic [7:0] mcr_wdata = 8'h00;
    logic [7:0] mcr_rdata;
    logic       msr_rd_en = 1'b0;
    logic [7:0] msr_rdata;
    logic       msi_o;
    logic       tx_bit_i = 1'b1;
    logic       tx_o;
    logic       rx_i = 1'b1;
    logic       rx_bit_o;
    logic       break_hold_o;
    logic       afc_en_i = 1'b0;
    logic       afc_active_o;
    logic       rts_n_o, dtr_n_o, op1_n_o, op2_n_o;
    logic [3:0] ext_n = 4'hF;   // {cd, ri, dsr, cts}, active low

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    uart_modem_loop #(.SYNC_STAGES(SYNC)) i_uart_modem_loop (
        .clk(clk), .rst_n(rst_n),
        .mcr_wr_en(mcr_wr_en), .mcr_wdata(mcr_wdata), .mcr_rdata(mcr_rdata),
        .msr_rd_en(msr_rd_en), .msr_rdata(msr_rdata), .msi_o(msi_o),
        .tx_bit_i(tx_bit_i), .tx_o(tx_o), .rx_i(rx_i), .rx_bit_o(rx_bit_o),
        .break_hold_o(break_hold_o), .afc_en_i(afc_en_i), .afc_active_o(afc_active_o),
        .rts_n_o(rts_n_o), .dtr_n_o(dtr_n_o), .op1_n_o(op1_n_o), .op2_n_o(op2_n_o),
        .cts_n_i(ext_n[0]), .dsr_n_i(ext_n[1]), .ri_n_i(ext_n[2]), .cd_n_i(ext_n[3])
    );

    // {loop, ctl[3:0]=op2,op1,rts,dtr, ext_n[3:0], exp status[3:0]=cd,ri,dsr,cts, exp pins=op2_n,op1_n,rts_n,dtr_n}
    localparam logic [16:0] VEC [7] = '{
        {1'b0, 4'b0000, 4'b1111, 4'b0000, 4'b1111},
        {1'b0, 4'b0011, 4'b0101, 4'b1010, 4'b1100},
        {1'b0, 4'b1100, 4'b1010, 4'b0101, 4'b0011},
        {1'b1, 4'b0011, 4'b0000, 4'b0011, 4'b1111},
        {1'b1, 4'b1100, 4'b1111, 4'b1100, 4'b1111},
        {1'b1, 4'b0101, 4'b0000, 4'b0110, 4'b1111},
        {1'b0, 4'b0000, 4'b1111, 4'b0000, 4'b1111}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_mcr(input logic [7:0] v);
        mcr_wdata = v;
        mcr_wr_en = 1'b1;
        @(negedge clk);
        mcr_wr_en = 1'b0;
    endtask

    task automatic read_msr(output logic [7:0] v);
        v = msr_rdata;
        msr_rd_en = 1'b1;
        @(negedge clk);
        msr_rd_en = 1'b0;
    endtask

    function automatic logic [7:0] pins();
        return {4'h0, op2_n_o, op1_n_o, rts_n_o, dtr_n_o};
    endfunction

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] rv;
        ticks(3);
        rst_n = 1'b1;
        ticks(1);

        // Reset state
        chk("R1 reset mcr", mcr_rdata, 8'h00);
        chk("R6 reset msr", msr_rdata, 8'h00);
        chk("R9 reset msi", {7'b0, msi_o}, 8'h00);
        chk("R2 reset pins", pins(), 8'h0F);
        chk("R11 reset hold", {7'b0, break_hold_o}, 8'h00);

        // Table walk
        for (int i = 0; i < 7; i++) begin
            ext_n = VEC[i][11:8];
            write_mcr({3'b000, VEC[i][16], VEC[i][15:12]});
            ticks(SYNC + 2);
            chk("R1 mcr readback", mcr_rdata, {3'b000, VEC[i][16], VEC[i][15:12]});
            chk(VEC[i][16] ? "R5 loop status" : "R6 pin status", {4'h0, msr_rdata[7:4]}, {4'h0, VEC[i][7:4]});
            chk(VEC[i][16] ? "R3 loop pins" : "R2 pin drive", pins(), {4'h0, VEC[i][3:0]});
            read_msr(rv);
        end
        ticks(1);
        chk("R9 msi after clear", {7'b0, msi_o}, 8'h00);

        // R1: upper bits discarded
        write_mcr(8'hE0);
        chk("R1 upper bits", mcr_rdata, 8'h00);

        // R7 latency and R8/R9 delta on CTS
        ext_n = 4'b1110;
        ticks(SYNC);
        chk("R7 not yet", msr_rdata, 8'h00);
        ticks(1);
        chk("R7 latency", msr_rdata, 8'h11);
        chk("R9 msi set", {7'b0, msi_o}, 8'h01);
        read_msr(rv);
        chk("R8 read clears", msr_rdata, 8'h10);
        chk("R9 msi cleared", {7'b0, msi_o}, 8'h00);
        ext_n = 4'b1111;
        ticks(SYNC + 2);
        read_msr(rv);

        // R8: RI trailing edge only
        ext_n = 4'b1011;
        ticks(SYNC + 2);
        chk("R8 RI rise no delta", msr_rdata, 8'h40);
        ext_n = 4'b1111;
        ticks(SYNC + 2);
        chk("R8 RI trailing edge", msr_rdata, 8'h04);
        read_msr(rv);

        // R2: serial path in normal mode
        tx_bit_i = 1'b0; rx_i = 1'b0;
        ticks(1);
        chk("R2 tx follow", {7'b0, tx_o}, 8'h00);
        chk("R2 rx follow", {7'b0, rx_bit_o}, 8'h00);
        rx_i = 1'b1;
        ticks(1);
        chk("R2 rx follow high", {7'b0, rx_bit_o}, 8'h01);

        // R10: flow control
        afc_en_i = 1'b1;
        ticks(1);
        chk("R10 afc normal", {7'b0, afc_active_o}, 8'h01);
        write_mcr(8'h10);
        chk("R10 afc loop", {7'b0, afc_active_o}, 8'h00);

        // R3/R4: loopback serial
        chk("R3 tx mark", {7'b0, tx_o}, 8'h01);
        chk("R4 rx from tx low", {7'b0, rx_bit_o}, 8'h00);
        rx_i = 1'b0;
        tx_bit_i = 1'b1;
        ticks(1);
        chk("R4 rx ignored", {7'b0, rx_bit_o}, 8'h01);
        rx_i = 1'b1;
        ticks(SYNC + 2);
        read_msr(rv);

        // R5: external pins ignored in loop
        ext_n = 4'b0000;
        ticks(SYNC + 3);
        chk("R5 ext ignored msr", msr_rdata, 8'h00);
        chk("R5 ext ignored msi", {7'b0, msi_o}, 8'h00);
        ext_n = 4'b1111;
        ticks(SYNC + 2);

        // R8: write-induced delta, retained through coincident read
        write_mcr(8'h12);
        read_msr(rv);
        chk("R8 delta kept during read", msr_rdata, 8'h11);
        read_msr(rv);
        chk("R8 cleared", msr_rdata, 8'h10);

        // R11: exit guard
        rx_i = 1'b0;
        ticks(SYNC + 2);
        write_mcr(8'h00);
        ticks(1);
        chk("R11 EXIT_HOLD", {7'b0, break_hold_o}, 8'h01);
        rx_i = 1'b1;
        ticks(SYNC);
        chk("R11 hold persists", {7'b0, break_hold_o}, 8'h01);
        ticks(1);
        chk("R11 RELEASE", {7'b0, break_hold_o}, 8'h00);

        // R11: clean exit
        write_mcr(8'h10);
        ticks(2);
        write_mcr(8'h00);
        ticks(2);
        chk("R11 EXIT_CLEAN", {7'b0, break_hold_o}, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule